// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 30-bit physical address. The page map has two levels and sits in main memory. The top ten address bits select an entry in a root table. The root table is always resident, and its physical page number comes from an input. That root entry names a second-level table page. The next ten bits select the final entry in that page, and the final entry gives the physical page number. The twelve low bits pass through unchanged as the offset. Virtual page 0 is wired to physical page 0 and never goes through translation.

An eight-slot, fully associative translation cache holds recent virtual-page to physical-page pairs. The walk reads memory only when this cache misses. Bit 31 of a page-map entry is the resident flag. If that flag is clear at either level, the request ends with a fault and nothing is put in the cache. A flush input empties the cache in one cycle and is raised on a context switch. Only one translation is in flight at a time, and only one memory read is outstanding at a time.

The controller is a state machine with seven states:

| State | What happens in it | Next state |
|---|---|---|
| IDLE | Accepts a request. | LOOKUP |
| LOOKUP | Checks for virtual page 0 and probes the cache. | RESP on virtual page 0 or a hit; ROOT_REQ on a miss |
| ROOT_REQ | Issues the root read. | ROOT_WAIT |
| ROOT_WAIT | Waits for the read data. | LEAF_REQ when the root entry is resident; RESP with a fault when it is not |
| LEAF_REQ | Issues the second-level read. | LEAF_WAIT |
| LEAF_WAIT | Waits for the read data and fills the cache when the entry is resident. | RESP |
| RESP | Presents the result for one cycle. | IDLE |

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the cache is empty, so the first non-zero page needs a full walk.
- R2: The root read address is {`root_base`, va[31:22], 2'b00}.
- R3: The second-level read address is {root entry bits 17:0, va[21:12], 2'b00}.
- R4: A resident walk returns `rsp_paddr` = {second-level entry bits 17:0, va[11:0]}. Entry bits 30:18 are ignored.
- R5: If bit 31 of the root entry is clear, the request ends after one read with `rsp_fault`=1 and `rsp_paddr`=0, and nothing is cached.
- R6: If bit 31 of the second-level entry is clear, the request ends after two reads with `rsp_fault`=1, and nothing is cached.
- R7: A request with va[31:12]=0 returns {18'b0, va[11:0]} without a fault and without any memory read.
- R8: On a cache hit, no read is issued, and `rsp_valid` rises in the second cycle after the request is accepted.
- R9: The cache holds 8 pairs and replaces them round-robin, so the ninth distinct fill evicts the oldest.
- R10: `flush` invalidates every cache entry in one cycle and returns the replacement pointer to slot 0.
- R11: `mem_req` is a one-cycle pulse with at most one read outstanding, and the walker waits for `mem_rvalid` however long the latency is.
- R12: `rsp_valid` is a one-cycle pulse, and `req_ready` returns in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidates the whole translation cache |
| root_base | input | 18 | Physical page number of the root table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_paddr | output | 30 | Physical address |
| rsp_fault | output | 1 | Page fault |
| mem_req | output | 1 | Memory read issue pulse |
| mem_addr | output | 30 | Byte address of the page-map entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page-map entry |

## Verification
Some properties are checked by assertions on every cycle:
- at most one cache slot matches a lookup;
- the cache is empty in the cycle after a flush;
- a read pulse is never followed directly by another one;
- the response pulse lasts one cycle;
- a hit issues no read;
- virtual page 0 never faults and always maps to page 0.

Other behaviour can only be shown by the bench's scenarios:
- the exact read addresses at each level;
- the masking of entry bits;
- that a fault leaves no cache fill behind;
- round-robin eviction order;
- hit latency;
- tolerance of slow memory.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int VPN_W   = 2 * IDX_W;
    localparam int PPN_W   = 18;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int PTE_W   = 32;
    localparam int RES_BIT = PTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ROOT_REQ,
        ST_ROOT_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_RESP
    } walk_state_t;
endpackage

// File: rtl/ptw_tcache.sv
module ptw_tcache #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    parameter int DATA_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] hit_vec;
    logic [TAG_W-1:0]   tags  [ENTRIES];
    logic [DATA_W-1:0]  datas [ENTRIES];
    logic [PTR_W-1:0]   ptr;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (tags[g] == lk_tag);
        end
    endgenerate

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_data = lk_data | datas[i];
        end
        lk_hit = |hit_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == LAST) ? '0 : PTR_W'(ptr + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tags[ptr]  <= fill_tag;
            datas[ptr] <= fill_data;
        end
    end

    assert_onehot_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PPN_W-1:0] root_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic [VPN_W-1:0] lk_tag,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_data,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_tag,
    output logic [PPN_W-1:0] fill_data
);
    walk_state_t state, state_nx;

    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] mid_ppn_q;
    logic [PA_W-1:0]  paddr_q;
    logic             fault_q;

    logic [VPN_W-1:0] vpn;
    logic [IDX_W-1:0] idx_root, idx_leaf;
    logic [OFF_W-1:0] off;
    logic             pte_res;
    logic [PPN_W-1:0] pte_ppn;
    logic             pte_unused;
    logic             is_page0;

    assign vpn        = va_q[VA_W-1:OFF_W];
    assign idx_root   = va_q[VA_W-1:OFF_W+IDX_W];
    assign idx_leaf   = va_q[OFF_W+IDX_W-1:OFF_W];
    assign off        = va_q[OFF_W-1:0];
    assign pte_res    = mem_rdata[RES_BIT];
    assign pte_ppn    = mem_rdata[PPN_W-1:0];
    assign pte_unused = ^mem_rdata[RES_BIT-1:PPN_W];
    assign is_page0   = (vpn == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP:    state_nx = (is_page0 || lk_hit) ? ST_RESP : ST_ROOT_REQ;
            ST_ROOT_REQ:  state_nx = ST_ROOT_WAIT;
            ST_ROOT_WAIT: if (mem_rvalid) state_nx = pte_res ? ST_LEAF_REQ : ST_RESP;
            ST_LEAF_REQ:  state_nx = ST_LEAF_WAIT;
            ST_LEAF_WAIT: if (mem_rvalid) state_nx = ST_RESP;
            ST_RESP:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            mid_ppn_q <= '0;
            paddr_q   <= '0;
            fault_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) va_q <= req_vaddr;
                ST_LOOKUP: begin
                    fault_q <= 1'b0;
                    if (is_page0) paddr_q <= {{PPN_W{1'b0}}, off};
                    else if (lk_hit) paddr_q <= {lk_data, off};
                end
                ST_ROOT_WAIT: if (mem_rvalid) begin
                    if (pte_res) mid_ppn_q <= pte_ppn;
                    else begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                    end
                end
                ST_LEAF_WAIT: if (mem_rvalid) begin
                    if (pte_res) paddr_q <= {pte_ppn, off};
                    else begin
                        fault_q <= 1'b1;
                        paddr_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
        mem_req   = (state == ST_ROOT_REQ) || (state == ST_LEAF_REQ);
        mem_addr  = (state == ST_ROOT_REQ) ? {root_base, idx_root, 2'b00}
                                           : {mid_ppn_q, idx_leaf, 2'b00};
        lk_tag    = vpn;
        fill_en   = (state == ST_LEAF_WAIT) && mem_rvalid && pte_res;
        fill_tag  = vpn;
        fill_data = pte_ppn;
    end

    assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_hit_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && lk_hit) |=> !mem_req);

    assert_page0_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && is_page0) |-> (!rsp_fault && rsp_paddr[PA_W-1:OFF_W] == '0));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import ptw_pkg::*;
#(
    parameter int TC_ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PPN_W-1:0] root_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    logic [VPN_W-1:0] lk_tag, fill_tag;
    logic [PPN_W-1:0] lk_data, fill_data;
    logic             lk_hit, fill_en;

    ptw_walk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_base  (root_base),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .fill_en    (fill_en),
        .fill_tag   (fill_tag),
        .fill_data  (fill_data)
    );

    ptw_tcache #(
        .ENTRIES (TC_ENTRIES),
        .TAG_W   (VPN_W),
        .DATA_W  (PPN_W)
    ) u_tcache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .fill_data (fill_data)
    );
endmodule

// File: tb/pgwalk_top_tb.sv
`timescale 1ns/1ps
module pgwalk_top_tb;
    localparam logic [17:0] ROOT = 18'h00100;
    localparam int LEAF_BASE = 'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_req;
    logic [29:0] rsp_paddr, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pgwalk_top u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .root_base(ROOT),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [17:0] ppn_of(int i, int j);
        return 18'(i * 64 + j * 5 + 3);
    endfunction

    function automatic logic [31:0] mem_model(logic [29:0] a);
        int idx = int'(a[11:2]);
        if (a[29:12] == ROOT)
            return {(idx != 5), 13'h0, 18'(LEAF_BASE + idx)};
        if (a[29:12] >= 18'(LEAF_BASE) && a[29:12] < 18'(LEAF_BASE + 1024))
            return {(idx != 7), 13'h15A5, ppn_of(int'(a[21:12]), idx)};
        return 32'h0;
    endfunction

    // memory responder
    int          mem_lat = 1;
    int          rd_count = 0;
    bit          pend = 0;
    int          cnt = 0;
    logic [29:0] cur_addr = '0;
    logic [29:0] addr_prev = '0, addr_last = '0;

    always @(negedge clk) begin
        if (mem_rvalid) mem_rvalid <= 1'b0;
        if (pend) begin
            if (cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_model(cur_addr);
                pend       <= 0;
            end else cnt <= cnt - 1;
        end
        if (rst_n && mem_req) begin
            pend      <= 1;
            cnt       <= mem_lat;
            cur_addr  <= mem_addr;
            rd_count  <= rd_count + 1;
            addr_prev <= addr_last;
            addr_last <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] va, output logic [29:0] pa, output logic flt,
                         output int cyc, output int reads, output bit pulse_ok);
        int r0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        r0 = rd_count;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        pa = rsp_paddr;
        flt = rsp_fault;
        reads = rd_count - r0;
        @(negedge clk);
        pulse_ok = !rsp_valid && req_ready;
    endtask

    function automatic logic [29:0] exp_pa(logic [31:0] va);
        int hi = int'(va[31:22]);
        int lo = int'(va[21:12]);
        if (va[31:12] == 0) return {18'h0, va[11:0]};
        return {ppn_of(hi, lo), va[11:0]};
    endfunction

    function automatic logic [31:0] mkva(int hi, int lo, int off);
        return {10'(hi), 10'(lo), 12'(off)};
    endfunction

    logic [29:0] pa;
    logic        flt;
    int          cyc, rds;
    bit          pok;

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_walk_basic();
        logic [31:0] va = mkva(1, 2, 'h345);
        xlate(va, pa, flt, cyc, rds, pok);
        chk(rds == 2, "R1 first access walks", 32'(rds), 2);
        chk(addr_prev == {ROOT, 10'd1, 2'b00}, "R2 root read address", 32'(addr_prev), 32'({ROOT, 10'd1, 2'b00}));
        chk(addr_last == {18'(LEAF_BASE + 1), 10'd2, 2'b00}, "R3 leaf read address",
            32'(addr_last), 32'({18'(LEAF_BASE + 1), 10'd2, 2'b00}));
        chk(pa == exp_pa(va) && !flt, "R4 walked paddr", 32'(pa), 32'(exp_pa(va)));
        chk(pok, "R12 single-cycle response then ready", 32'(pok), 1);
    endtask

    task automatic t_hit();
        logic [31:0] va = mkva(1, 2, 'hFFF);
        xlate(va, pa, flt, cyc, rds, pok);
        chk(rds == 0, "R8 hit issues no read", 32'(rds), 0);
        chk(cyc == 1, "R8 hit latency", 32'(cyc), 1);
        chk(pa == exp_pa(va) && !flt, "R8 hit paddr", 32'(pa), 32'(exp_pa(va)));
    endtask

    task automatic t_page0();
        xlate(32'h0000_0ABC, pa, flt, cyc, rds, pok);
        chk(rds == 0, "R7 page 0 no read", 32'(rds), 0);
        chk(pa == 30'hABC && !flt, "R7 page 0 identity", 32'(pa), 32'hABC);
    endtask

    task automatic t_root_fault();
        logic [31:0] va = mkva(5, 1, 'h10);
        for (int k = 0; k < 2; k++) begin
            xlate(va, pa, flt, cyc, rds, pok);
            chk(flt == 1'b1, "R5 root fault flagged", 32'(flt), 1);
            chk(rds == 1, "R5 root fault one read, no fill", 32'(rds), 1);
            chk(pa == '0, "R5 fault paddr zero", 32'(pa), 0);
        end
    endtask

    task automatic t_leaf_fault();
        logic [31:0] va = mkva(3, 7, 'h20);
        for (int k = 0; k < 2; k++) begin
            xlate(va, pa, flt, cyc, rds, pok);
            chk(flt == 1'b1, "R6 leaf fault flagged", 32'(flt), 1);
            chk(rds == 2, "R6 leaf fault two reads, no fill", 32'(rds), 2);
        end
    endtask

    task automatic t_slow_mem();
        logic [31:0] va = mkva(9, 4, 'h77);
        mem_lat = 6;
        xlate(va, pa, flt, cyc, rds, pok);
        chk(rds == 2, "R11 slow memory two reads", 32'(rds), 2);
        chk(pa == exp_pa(va) && !flt, "R11 slow memory paddr", 32'(pa), 32'(exp_pa(va)));
        mem_lat = 1;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_flush();
        do_flush();
        xlate(mkva(1, 2, 'h1), pa, flt, cyc, rds, pok);
        chk(rds == 2, "R10 flush forces walk", 32'(rds), 2);
    endtask

    task automatic t_round_robin();
        do_flush();
        for (int k = 10; k < 18; k++) xlate(mkva(12, k, 0), pa, flt, cyc, rds, pok);
        xlate(mkva(12, 20, 0), pa, flt, cyc, rds, pok);
        xlate(mkva(12, 11, 'h5), pa, flt, cyc, rds, pok);
        chk(rds == 0, "R9 second-oldest survives", 32'(rds), 0);
        xlate(mkva(12, 10, 'h5), pa, flt, cyc, rds, pok);
        chk(rds == 2, "R9 oldest evicted by ninth fill", 32'(rds), 2);
        chk(pa == exp_pa(mkva(12, 10, 'h5)), "R9 refill paddr", 32'(pa), 32'(exp_pa(mkva(12, 10, 'h5))));
        xlate(mkva(12, 20, 'h9), pa, flt, cyc, rds, pok);
        chk(rds == 0, "R9 ninth entry resident", 32'(rds), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk_basic();
        t_hit();
        t_page0();
        t_root_fault();
        t_leaf_fault();
        t_slow_mem();
        t_flush();
        t_round_robin();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule